// File: doc/BRIEF.md
# Tiled Integer Matrix Multiply-Accumulate Engine

This block computes one output tile of C = A×B + bias for signed integer operands. Per K chunk, the left operand is a TM×TK tile and the right operand is a TK×TN tile. Each arrives as its own element stream with a valid/ready handshake. The engine holds a TM×TN accumulator that persists from chunk to chunk, so a long reduction dimension can be fed as several chunks. Two chunk flags travel with the left stream. The start flag makes the engine seed the accumulator with a 1×TN bias row, and that row is applied to every result row. The end flag makes the engine stream the finished tile out after the chunk has been folded in.

A chunk is computed in a single cycle, once both operand tiles have been fully collected. The operand stores are then freed at once. Both operand stores may collect the next chunk while the previous tile is still draining, but the next compute waits until the drain has finished. The accumulator is wide enough that MAX_KCH chunks of extreme operands plus an extreme bias cannot wrap.

Top module: `tile_mac_engine`

## Requirements
- R1: After reset, `res_valid` is 0, the accumulator is zero, and both `lhs_ready` and `rhs_ready` are 1.
- R2: The left store takes exactly TM×TK elements, in row-major order (element index i·TK+k). The right store takes exactly TK×TN elements, also row-major (index k·TN+j). Each ready drops once its store is full and stays low until the chunk is computed.
- R3: `lhs_first` and `lhs_last` are sampled only on the cycle that the first left element of a chunk is accepted.
- R4: For a chunk flagged first, every result entry (i,j) becomes bias[j] + Σk A[i][k]·B[k][j]. bias[j] is the signed value in `bias_row[j*2*DW +: 2*DW]`.
- R5: For a chunk not flagged first, every entry (i,j) gains Σk A[i][k]·B[k][j] on top of its previous value.
- R6: The compute takes place on the first clock edge at which both stores are full and no tile is draining. Both readies return to 1 on the cycle after that edge.
- R7: A chunk flagged last starts the output on the cycle after its compute. The output carries TM×TN entries in row-major order (index i·TN+j), and `res_last` is 1 on the final entry only.
- R8: While `res_valid` is 1 and `res_ready` is 0, both `res_data` and `res_last` stay unchanged.
- R9: During a drain, operands for the next chunk are still accepted. The compute of that chunk waits until the final output entry has been accepted.
- R10: The accumulator holds 2·DW + clog2(TK·MAX_KCH) + 1 bits. Up to MAX_KCH chunks of any operand values, plus any bias, give the exact result.
- R11: A chunk not flagged last produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lhs_valid | input | 1 | Left element valid |
| lhs_ready | output | 1 | Left store can take an element |
| lhs_data | input | DW | Signed left element |
| lhs_first | input | 1 | Chunk seeds accumulator with bias |
| lhs_last | input | 1 | Chunk is final; tile is output after it |
| rhs_valid | input | 1 | Right element valid |
| rhs_ready | output | 1 | Right store can take an element |
| rhs_data | input | DW | Signed right element |
| bias_row | input | TN*2*DW | Bias row, entry j in bits [j*2*DW +: 2*DW]; must be stable while a first chunk is pending |
| res_valid | output | 1 | Output entry valid |
| res_ready | input | 1 | Consumer takes the output entry |
| res_data | output | ACC_W | Signed result entry |
| res_last | output | 1 | Final entry of the tile |

## Verification
The case that matters is two functions landing in the same cycles: the draining of a finished tile, and the loading of the next chunk's operands. The bench provokes this by holding `res_ready` low so the drain stalls while both operand streams are fed. The stores must then fill and their readies drop, and the compute must stay blocked until the last output entry is taken. A behavioural model steps through every cycle and judges the readies, the output valid, data and last flag against its own view of when the stores fill, when the compute happens and which entry is due.

// File: rtl/tmac_pkg.sv
package tmac_pkg;

  typedef enum logic [0:0] {
    PH_LOAD  = 1'b0,
    PH_DRAIN = 1'b1
  } tmac_phase_e;

endpackage

// File: rtl/tmac_opbuf.sv
module tmac_opbuf #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DW-1:0]         in_data,
  input  logic                  release_i,
  output logic                  full_o,
  output logic                  empty_o,
  output logic                  accept_o,
  output logic [DEPTH*DW-1:0]   data_o
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] fill_cnt;
  logic [DW-1:0] slot [DEPTH];

  assign full_o   = (fill_cnt == CW'(DEPTH));
  assign empty_o  = (fill_cnt == '0);
  assign in_ready = !full_o;
  assign accept_o = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt <= '0;
    end else if (release_i) begin
      fill_cnt <= '0;
    end else if (accept_o) begin
      fill_cnt <= fill_cnt + CW'(1);
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot[e] <= '0;
      end else if (accept_o && (fill_cnt == CW'(e))) begin
        slot[e] <= in_data;
      end
    end
    assign data_o[e*DW +: DW] = slot[e];
  end

  // R2: a full store keeps its contents until it is released
  a_r2_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    full_o && !release_i |=> full_o && $stable(data_o));

  // R6: after release the store is empty and ready again
  a_r6_release_empty: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> empty_o && in_ready);

endmodule

// File: rtl/tmac_accum.sv
module tmac_accum #(
  parameter int DW    = 8,
  parameter int TM    = 2,
  parameter int TN    = 2,
  parameter int TK    = 2,
  parameter int PW    = 16,
  parameter int ACC_W = 20,
  parameter int IW    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     calc_i,
  input  logic                     seed_i,
  input  logic [TM*TK*DW-1:0]      a_flat,
  input  logic [TK*TN*DW-1:0]      b_flat,
  input  logic [TN*PW-1:0]         bias_flat,
  input  logic [IW-1:0]            rd_idx,
  output logic signed [ACC_W-1:0]  rd_data
);

  localparam int A_W = TM*TK*DW;
  localparam int B_W = TK*TN*DW;
  localparam int C_N = TM*TN;

  // sum over k of A[row][k] * B[k][col], exact in ACC_W bits
  function automatic logic signed [ACC_W-1:0] dot_at(
    input logic [A_W-1:0] af,
    input logic [B_W-1:0] bf,
    input int             row,
    input int             col
  );
    logic signed [ACC_W-1:0] s;
    logic signed [PW-1:0]    xa;
    logic signed [PW-1:0]    xb;
    logic signed [PW-1:0]    p;
    s = '0;
    for (int k = 0; k < TK; k++) begin
      xa = PW'($signed(af[(row*TK+k)*DW +: DW]));
      xb = PW'($signed(bf[(k*TN+col)*DW +: DW]));
      p  = xa * xb;
      s  = s + ACC_W'(p);
    end
    return s;
  endfunction

  logic signed [ACC_W-1:0] acc [C_N];

  for (genvar gi = 0; gi < TM; gi++) begin : g_row
    for (genvar gj = 0; gj < TN; gj++) begin : g_col
      localparam int E = gi*TN + gj;
      logic signed [ACC_W-1:0] part_sum;
      logic signed [ACC_W-1:0] base_val;
      logic signed [ACC_W:0]   wide_sum;

      assign part_sum = dot_at(a_flat, b_flat, gi, gj);
      assign base_val = seed_i ? ACC_W'($signed(bias_flat[gj*PW +: PW])) : acc[E];
      assign wide_sum = {base_val[ACC_W-1], base_val} + {part_sum[ACC_W-1], part_sum};

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          acc[E] <= '0;
        end else if (calc_i) begin
          acc[E] <= wide_sum[ACC_W-1:0];
        end
      end

      // R10: the sum never needs the extra bit
      a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        calc_i |-> (wide_sum[ACC_W] == wide_sum[ACC_W-1]));

      // R5: the accumulator only moves on a compute
      a_r5_hold_acc: assert property (@(posedge clk) disable iff (!rst_n)
        !calc_i |=> $stable(acc[E]));
    end
  end

  assign rd_data = acc[rd_idx];

endmodule

// File: rtl/tmac_drain.sv
module tmac_drain #(
  parameter int C_N = 4,
  parameter int IW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_last,
  output logic [IW-1:0] rd_idx,
  output logic          done_o
);

  logic active;
  logic fire;

  assign out_valid = active;
  assign out_last  = active && (rd_idx == IW'(C_N-1));
  assign fire      = active && out_ready;
  assign done_o    = fire && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      rd_idx <= '0;
    end else if (start_i) begin
      active <= 1'b1;
      rd_idx <= '0;
    end else if (fire) begin
      if (out_last) begin
        active <= 1'b0;
        rd_idx <= '0;
      end else begin
        rd_idx <= rd_idx + IW'(1);
      end
    end
  end

  // R7: the tile ends after the entry flagged last
  a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !out_valid);

  // R8: a stalled entry does not advance
  a_r8_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(rd_idx));

endmodule

// File: rtl/tile_mac_engine.sv
module tile_mac_engine
  import tmac_pkg::*;
#(
  parameter int DW      = 8,
  parameter int TM      = 2,
  parameter int TN      = 2,
  parameter int TK      = 2,
  parameter int MAX_KCH = 4,
  localparam int PW     = 2*DW,
  localparam int ACC_W  = PW + $clog2(TK*MAX_KCH) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lhs_valid,
  output logic                    lhs_ready,
  input  logic [DW-1:0]           lhs_data,
  input  logic                    lhs_first,
  input  logic                    lhs_last,
  input  logic                    rhs_valid,
  output logic                    rhs_ready,
  input  logic [DW-1:0]           rhs_data,
  input  logic [TN*PW-1:0]        bias_row,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic signed [ACC_W-1:0] res_data,
  output logic                    res_last
);

  localparam int A_N = TM*TK;
  localparam int B_N = TK*TN;
  localparam int C_N = TM*TN;
  localparam int IW  = (C_N > 1) ? $clog2(C_N) : 1;

  tmac_phase_e phase;

  logic              a_full, a_empty, a_accept;
  logic              b_full, b_empty, b_accept;
  logic [A_N*DW-1:0] a_flat;
  logic [B_N*DW-1:0] b_flat;
  logic              chunk_first, chunk_last;
  logic              calc_fire;
  logic              drain_start, drain_done;
  logic [IW-1:0]     rd_idx;

  assign calc_fire   = (phase == PH_LOAD) && a_full && b_full;
  assign drain_start = calc_fire && chunk_last;

  tmac_opbuf #(.DW(DW), .DEPTH(A_N)) i_lhs_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (lhs_valid),
    .in_ready  (lhs_ready),
    .in_data   (lhs_data),
    .release_i (calc_fire),
    .full_o    (a_full),
    .empty_o   (a_empty),
    .accept_o  (a_accept),
    .data_o    (a_flat)
  );

  tmac_opbuf #(.DW(DW), .DEPTH(B_N)) i_rhs_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rhs_valid),
    .in_ready  (rhs_ready),
    .in_data   (rhs_data),
    .release_i (calc_fire),
    .full_o    (b_full),
    .empty_o   (b_empty),
    .accept_o  (b_accept),
    .data_o    (b_flat)
  );

  // chunk flags travel with the first left element
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chunk_first <= 1'b0;
      chunk_last  <= 1'b0;
    end else if (a_accept && a_empty) begin
      chunk_first <= lhs_first;
      chunk_last  <= lhs_last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_LOAD;
    end else if (drain_start) begin
      phase <= PH_DRAIN;
    end else if (drain_done) begin
      phase <= PH_LOAD;
    end
  end

  tmac_accum #(
    .DW(DW), .TM(TM), .TN(TN), .TK(TK), .PW(PW), .ACC_W(ACC_W), .IW(IW)
  ) i_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .calc_i    (calc_fire),
    .seed_i    (chunk_first),
    .a_flat    (a_flat),
    .b_flat    (b_flat),
    .bias_flat (bias_row),
    .rd_idx    (rd_idx),
    .rd_data   (res_data)
  );

  tmac_drain #(.C_N(C_N), .IW(IW)) i_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (drain_start),
    .out_ready (res_ready),
    .out_valid (res_valid),
    .out_last  (res_last),
    .rd_idx    (rd_idx),
    .done_o    (drain_done)
  );

  // R6: a compute only uses two complete operand tiles
  a_r6_calc_both: assert property (@(posedge clk) disable iff (!rst_n)
    calc_fire |-> a_full && b_full && !a_empty && !b_empty);

  // R9: no compute while a tile is still leaving
  a_r9_no_calc_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !calc_fire);

  // R8: stalled output keeps data and last flag
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_last));

  // R11: a chunk not flagged last leaves the output idle
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    calc_fire && !chunk_last |=> !res_valid);

  // R7: a last chunk starts the output on the next cycle
  a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
    calc_fire && chunk_last |=> res_valid);

endmodule

// File: tb/test_tile_mac_engine.sv
module test_tile_mac_engine;

  localparam int DW = 8, TM = 2, TN = 2, TK = 2, MAX_KCH = 4;
  localparam int PW = 2*DW;
  localparam int ACC_W = PW + $clog2(TK*MAX_KCH) + 1;
  localparam int A_N = TM*TK, B_N = TK*TN, C_N = TM*TN;

  logic clk = 0, rst_n = 0;
  logic lhs_valid = 0, lhs_first = 0, lhs_last = 0, rhs_valid = 0, res_ready = 1;
  logic [DW-1:0] lhs_data = '0, rhs_data = '0;
  logic [TN*PW-1:0] bias_row = '0;
  logic lhs_ready, rhs_ready, res_valid, res_last;
  logic signed [ACC_W-1:0] res_data;

  always #5 clk = ~clk;

  tile_mac_engine #(.DW(DW), .TM(TM), .TN(TN), .TK(TK), .MAX_KCH(MAX_KCH)) i_tile_mac_engine (
    .clk(clk), .rst_n(rst_n),
    .lhs_valid(lhs_valid), .lhs_ready(lhs_ready), .lhs_data(lhs_data),
    .lhs_first(lhs_first), .lhs_last(lhs_last),
    .rhs_valid(rhs_valid), .rhs_ready(rhs_ready), .rhs_data(rhs_data),
    .bias_row(bias_row),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_last(res_last)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string cur_tag = "R4";
  int rdy_mode = 0;
  bit gaps = 0;

  int sa [A_N];
  int sb [B_N];
  int bias_v [TN];

  // behavioural model state
  int ma [A_N];
  int mb [B_N];
  int macc [C_N];
  int ma_cnt = 0, mb_cnt = 0, m_idx = 0;
  bit m_first = 0, m_last = 0, m_drain = 0, m_just = 0, m_stall = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // per-cycle comparison and model step (the step stands for the next rising edge)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit a_fire, b_fire, calc, exp_ar, exp_br;
      exp_ar = (ma_cnt < A_N);
      exp_br = (mb_cnt < B_N);
      chk(m_drain ? "R9" : "R2", int'(lhs_ready), int'(exp_ar));
      chk(m_drain ? "R9" : "R2", int'(rhs_ready), int'(exp_br));
      chk(m_just ? "R6" : (m_drain ? "R7" : "R11"), int'(res_valid), int'(m_drain));
      if (m_drain) begin
        chk(m_stall ? "R8" : cur_tag, int'(res_data), macc[m_idx]);
        chk(m_stall ? "R8" : "R7", int'(res_last), int'(m_idx == C_N-1));
      end
      a_fire = lhs_valid && exp_ar;
      b_fire = rhs_valid && exp_br;
      calc = !m_drain && (ma_cnt == A_N) && (mb_cnt == B_N);
      m_just = 0;
      m_stall = m_drain && !res_ready;
      if (m_drain && res_ready) begin
        if (m_idx == C_N-1) begin m_drain = 0; m_idx = 0; end
        else m_idx++;
      end
      if (calc) begin
        for (int i = 0; i < TM; i++)
          for (int j = 0; j < TN; j++) begin
            int s;
            s = m_first ? bias_v[j] : macc[i*TN+j];
            for (int k = 0; k < TK; k++) s += ma[i*TK+k] * mb[k*TN+j];
            macc[i*TN+j] = s;
          end
        ma_cnt = 0; mb_cnt = 0;
        if (m_last) begin m_drain = 1; m_idx = 0; m_just = 1; end
      end else begin
        if (a_fire) begin
          if (ma_cnt == 0) begin m_first = lhs_first; m_last = lhs_last; end
          ma[ma_cnt] = int'($signed(lhs_data));
          ma_cnt++;
        end
        if (b_fire) begin
          mb[mb_cnt] = int'($signed(rhs_data));
          mb_cnt++;
        end
      end
    end
  end

  // consumer readiness
  initial begin
    forever begin
      @(posedge clk); #1;
      case (rdy_mode)
        0: res_ready = 1;
        1: res_ready = 1'($urandom_range(0, 1));
        default: res_ready = 0;
      endcase
    end
  end

  task automatic idle_gap();
    if (gaps) repeat ($urandom_range(0, 2)) begin @(posedge clk); #1; end
  endtask

  task automatic push_a(input bit first, input bit last);
    lhs_first = first; lhs_last = last;
    for (int e = 0; e < A_N; e++) begin
      lhs_valid = 0; idle_gap();
      lhs_valid = 1; lhs_data = sa[e][DW-1:0];
      @(negedge clk); while (!lhs_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    lhs_valid = 0;
  endtask

  task automatic push_b();
    for (int e = 0; e < B_N; e++) begin
      rhs_valid = 0; idle_gap();
      rhs_valid = 1; rhs_data = sb[e][DW-1:0];
      @(negedge clk); while (!rhs_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    rhs_valid = 0;
  endtask

  task automatic set_bias_rand();
    for (int j = 0; j < TN; j++) begin
      bias_v[j] = $urandom_range(0, 65535) - 32768;
      bias_row[j*PW +: PW] = bias_v[j][PW-1:0];
    end
  endtask

  task automatic rand_ops();
    for (int e = 0; e < A_N; e++) sa[e] = $urandom_range(0, 255) - 128;
    for (int e = 0; e < B_N; e++) sb[e] = $urandom_range(0, 255) - 128;
  endtask

  task automatic chunk(input bit first, input bit last);
    fork
      push_a(first, last);
      push_b();
    join
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_drain || ma_cnt != 0 || mb_cnt != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk("R1", int'(res_valid), 0);
    chk("R1", int'(lhs_ready), 1);
    chk("R1", int'(rhs_ready), 1);
    @(posedge clk); #1; rst_n = 1;

    // R1: a non-first last chunk on a fresh engine adds onto a zero accumulator
    cur_tag = "R1"; set_bias_rand(); rand_ops(); chunk(0, 1); wait_idle();

    // R4: single seeded chunk
    cur_tag = "R4"; set_bias_rand(); rand_ops(); chunk(1, 1); wait_idle();

    // R5: continue accumulating on the previous tile
    cur_tag = "R5"; rand_ops(); chunk(0, 1); wait_idle();

    // R3 R5: three chunks, input gaps, random backpressure
    cur_tag = "R3"; gaps = 1; rdy_mode = 1; set_bias_rand();
    rand_ops(); chunk(1, 0);
    rand_ops(); chunk(0, 0);
    rand_ops(); chunk(0, 1); wait_idle();

    // R10: extreme values over MAX_KCH chunks
    cur_tag = "R10"; gaps = 0; rdy_mode = 0;
    for (int j = 0; j < TN; j++) begin bias_v[j] = 32767; bias_row[j*PW +: PW] = 16'sd32767; end
    for (int e = 0; e < A_N; e++) sa[e] = -128;
    for (int e = 0; e < B_N; e++) sb[e] = -128;
    for (int c = 0; c < MAX_KCH; c++) chunk(c == 0, c == MAX_KCH-1);
    wait_idle();
    chk("R10", macc[0], TK*MAX_KCH*16384 + 32767);

    // R9: next chunk loads while the drain is stalled
    cur_tag = "R9"; rdy_mode = 2; set_bias_rand();
    rand_ops(); chunk(1, 1);
    rand_ops(); chunk(1, 1);
    repeat (6) @(posedge clk);
    #1; @(negedge clk);
    chk("R9", int'(lhs_ready), 0);
    chk("R9", int'(res_valid), 1);
    @(posedge clk); #1;
    rdy_mode = 1; wait_idle();

    // R11: non-last chunk stays silent, then finish the tile
    cur_tag = "R11"; rdy_mode = 0; set_bias_rand();
    rand_ops(); chunk(1, 0);
    repeat (8) begin @(negedge clk); chk("R11", int'(res_valid), 0); end
    @(posedge clk); #1;
    rand_ops(); chunk(0, 1); wait_idle();

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule